// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex character transmitter and receiver for start/stop framed serial lines. Both halves run from one system clock. A single-cycle oversample enable, `os_tick_i`, sets the line rate: one bit time lasts 16, 32 or 64 ticks, chosen at run time. Four configuration inputs select the character length, the parity type, the stop period and the oversampling ratio. Each direction captures these inputs when a character begins, so the software can change them at any time.

The transmitter takes a byte over a valid/ready handshake. It sends a low start bit, then the data bits least-significant first, then an optional parity bit, then a high stop period. On command it drives a continuous break. The receiver synchronises the line and checks each start edge half a bit later. It then samples every bit at its centre. When it has rebuilt a character, it gives a one-cycle valid strobe with the data and with parity, framing and break flags.

Top module: `async_xcvr`

## Requirements
- R1: After reset, and whenever the transmitter is idle, `txd_o` is high, `tx_ready_o` is high unless break is requested, and `rx_valid_o` is low.
- R2: A transmitted character is one low start bit, then `cfg_len_i+1` data bits, least-significant first. Each bit lasts one bit time. Data bits above the selected length are ignored.
- R3: `cfg_par_i` selects the parity bit that follows the data: 0 none, 1 odd (the total count of ones is odd), 2 even, 3 mark (always 1), 4 space (always 0). Codes 5 to 7 act as none.
- R4: The high stop period lasts `(cfg_stop_i+1)/16` bit times, from 1/16 up to 2 bits. `tx_ready_o` rises exactly when the stop period ends.
- R5: `cfg_os_i` sets the bit time in `os_tick_i` ticks: 0 gives 16, 1 gives 32, 2 or 3 give 64.
- R6: A byte is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` stays low until that character ends, and the transmitter ignores `tx_valid_i` while it is busy.
- R7: While `tx_break_i` is high, the transmitter first finishes any character in progress. It then holds `txd_o` continuously low and keeps `tx_ready_o` low. On release the line returns high.
- R8: For each character it receives, the receiver pulses `rx_valid_o` for exactly one cycle. `rx_data_o` holds the data bits, zero-extended above the selected length.
- R9: The receiver checks a falling edge again half a bit time later. If the line is high at that point, the edge is dropped as noise and no character is reported.
- R10: `rx_par_err_o` is set with the strobe when parity is enabled and the received parity bit differs from the one the data requires.
- R11: `rx_frm_err_o` is set with the strobe when the stop sample, taken in the middle of the stop period, is low.
- R12: A character whose bits, including parity and stop, are all zero is reported with `rx_brk_o` high, data zero and both error flags low. The receiver then accepts no new start until it has sampled the line high.
- R13: A change to the configuration inputs in the middle of a character does not affect that character in either direction. The change applies from the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample enable, one cycle per tick |
| cfg_len_i | input | 3 | Data bits per character minus one |
| cfg_par_i | input | 3 | Parity type code |
| cfg_stop_i | input | 5 | Stop period in sixteenths of a bit, minus one |
| cfg_os_i | input | 2 | Oversampling ratio select |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| tx_break_i | input | 1 | Request continuous break |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| rx_valid_o | output | 1 | One-cycle strobe for a received character |
| rx_data_o | output | 8 | Received data, zero-extended |
| rx_par_err_o | output | 1 | Parity error flag for the strobed character |
| rx_frm_err_o | output | 1 | Framing error flag for the strobed character |
| rx_brk_o | output | 1 | Break flag for the strobed character |

## Verification
Assertions check properties on every cycle:
- The idle line is high.
- The line stays low while the transmitter is in break.
- An accepted byte drops ready on the next cycle.
- Every receive strobe lasts one cycle.
- A break report carries zero data and no error flags.

Only the bench scenarios can show the serial timing. They sample the line at computed bit centres for each length, parity type, stop period and ratio. They also cover noise rejection, injected parity and framing faults, break with its wait-for-high recovery, and a configuration change in the middle of a character.

// File: rtl/async_xcvr_pkg.sv
package async_xcvr_pkg;
  localparam int DATA_W      = 8;
  localparam int LEN_W       = 3;
  localparam int STOP_W      = 5;
  localparam int OS_SEL_W    = 2;
  localparam int OS_BASE_LOG = 4;
  localparam int OS_MAX_EXTRA = 2;
  localparam int CNT_W       = OS_BASE_LOG + OS_MAX_EXTRA + 2;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(DATA_W - 1);

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef struct packed {
    logic [LEN_W-1:0]    len;
    logic [2:0]          par;
    logic [STOP_W-1:0]   stop;
    logic [OS_SEL_W-1:0] os;
  } cfg_t;

  function automatic logic [1:0] os_extra(input logic [OS_SEL_W-1:0] os);
    return (os == 2'd0) ? 2'd0 : (os == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [CNT_W-1:0] bit_ticks(input logic [OS_SEL_W-1:0] os);
    return CNT_ONE << (OS_BASE_LOG + int'(os_extra(os)));
  endfunction

  // stop period in ticks: (stop+1) sixteenths of a bit
  function automatic logic [CNT_W-1:0] stop_ticks(input logic [OS_SEL_W-1:0] os,
                                                  input logic [STOP_W-1:0] stop);
    return (CNT_W'(stop) + CNT_ONE) << os_extra(os);
  endfunction

  function automatic logic par_used(input logic [2:0] mode);
    return (mode != PAR_NONE) && (mode <= PAR_SPACE);
  endfunction

  function automatic logic par_bit(input logic [2:0] mode, input logic [DATA_W-1:0] d);
    case (mode)
      PAR_ODD:  return ~^d;
      PAR_EVEN: return ^d;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    return {DATA_W{1'b1}} >> (LEN_TOP - len);
  endfunction
endpackage

// File: rtl/async_tx.sv
module async_tx
  import async_xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  cfg_t              cfg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              brk_i,
  output logic              txd_o
);
  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK} tx_st_e;

  tx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  cfg_t              cfg_q;
  logic              txd_q;
  logic [CNT_W-1:0]  bt;
  logic [CNT_W-1:0]  stp;
  logic              bit_end;
  logic [DATA_W-1:0] data_m;

  assign bt      = bit_ticks(cfg_q.os);
  assign stp     = stop_ticks(cfg_q.os, cfg_q.stop);
  assign bit_end = tick_i && (cnt_q == bt - CNT_ONE);
  assign data_m  = data_i & len_mask(cfg_i.len);
  assign ready_o = (st_q == TX_IDLE) && !brk_i;
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      cfg_q <= '0;
      txd_q <= 1'b1;
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (brk_i) begin
            st_q  <= TX_BRK;
            txd_q <= 1'b0;
          end else if (valid_i) begin
            cfg_q <= cfg_i;  // configuration captured at character start
            sh_q  <= data_m;
            par_q <= par_bit(cfg_i.par, data_m);
            cnt_q <= '0;
            st_q  <= TX_START;
            txd_q <= 1'b0;
          end
        end
        TX_BRK: begin
          if (!brk_i) begin
            st_q  <= TX_IDLE;
            txd_q <= 1'b1;
          end
        end
        TX_START: begin
          if (bit_end) begin
            cnt_q <= '0;
            idx_q <= '0;
            txd_q <= sh_q[0];
            st_q  <= TX_DATA;
          end else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (idx_q == cfg_q.len) begin
              if (par_used(cfg_q.par)) begin
                st_q  <= TX_PAR;
                txd_q <= par_q;
              end else begin
                st_q  <= TX_STOP;
                txd_q <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + LEN_ONE;
              sh_q  <= sh_q >> 1;
              txd_q <= sh_q[1];
            end
          end else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
        end
        TX_PAR: begin
          if (bit_end) begin
            cnt_q <= '0;
            st_q  <= TX_STOP;
            txd_q <= 1'b1;
          end else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
        end
        TX_STOP: begin
          if (tick_i) begin
            if (cnt_q == stp - CNT_ONE) begin
              cnt_q <= '0;
              st_q  <= TX_IDLE;
            end else cnt_q <= cnt_q + CNT_ONE;
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> txd_o);

  assert_break_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_BRK) |-> !txd_o);

  assert_accept_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!ready_o && !txd_o));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  cfg_t              cfg_i,
  input  logic              rxd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rx_st_e;

  rx_st_e            st_q;
  logic              s1_q, s2_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_s_q;
  logic              zero_q;
  cfg_t              cfg_q;
  logic              valid_q, pe_q, fe_q, bk_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  bt, half, stop_at;
  logic [DATA_W-1:0] word;
  logic              line;
  logic              bit_end;

  assign line    = s2_q;
  assign bt      = bit_ticks(cfg_q.os);
  assign half    = bt >> 1;
  // sample the middle of the stop period, measured from the last bit centre
  assign stop_at = half + (stop_ticks(cfg_q.os, cfg_q.stop) >> 1) - CNT_ONE;
  assign bit_end = tick_i && (cnt_q == bt - CNT_ONE);
  assign word    = sh_q >> (LEN_TOP - cfg_q.len);

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign par_err_o = pe_q;
  assign frm_err_o = fe_q;
  assign brk_o     = bk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_s_q <= 1'b0;
      zero_q  <= 1'b0;
      cfg_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      bk_q    <= 1'b0;
    end else begin
      s1_q    <= rxd_i;
      s2_q    <= s1_q;
      valid_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (tick_i && !line) begin
            cfg_q <= cfg_i;
            cnt_q <= '0;
            st_q  <= RX_START;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (cnt_q == half - CNT_ONE) begin
              cnt_q <= '0;
              if (line) st_q <= RX_IDLE;  // glitch, not a start bit
              else begin
                idx_q  <= '0;
                zero_q <= 1'b1;
                st_q   <= RX_DATA;
              end
            end else cnt_q <= cnt_q + CNT_ONE;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q  <= '0;
            sh_q   <= {line, sh_q[DATA_W-1:1]};
            zero_q <= zero_q & ~line;
            if (idx_q == cfg_q.len) st_q <= par_used(cfg_q.par) ? RX_PAR : RX_STOP;
            else idx_q <= idx_q + LEN_ONE;
          end else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
        end
        RX_PAR: begin
          if (bit_end) begin
            cnt_q   <= '0;
            par_s_q <= line;
            zero_q  <= zero_q & ~line;
            st_q    <= RX_STOP;
          end else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
        end
        RX_STOP: begin
          if (tick_i) begin
            if (cnt_q == stop_at) begin
              cnt_q   <= '0;
              valid_q <= 1'b1;
              if (zero_q && !line) begin
                bk_q   <= 1'b1;
                data_q <= '0;
                pe_q   <= 1'b0;
                fe_q   <= 1'b0;
                st_q   <= RX_WAIT;
              end else begin
                bk_q   <= 1'b0;
                data_q <= word;
                fe_q   <= !line;
                pe_q   <= par_used(cfg_q.par) && (par_s_q != par_bit(cfg_q.par, word));
                st_q   <= RX_IDLE;
              end
            end else cnt_q <= cnt_q + CNT_ONE;
          end
        end
        RX_WAIT: begin
          if (tick_i && line) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_break_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && brk_o) |-> (data_o == '0 && !par_err_o && !frm_err_o));
endmodule

// File: rtl/async_xcvr.sv
module async_xcvr
  import async_xcvr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        os_tick_i,
  input  logic [2:0]  cfg_len_i,
  input  logic [2:0]  cfg_par_i,
  input  logic [4:0]  cfg_stop_i,
  input  logic [1:0]  cfg_os_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  input  logic        tx_break_i,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic        rx_valid_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_par_err_o,
  output logic        rx_frm_err_o,
  output logic        rx_brk_o
);
  cfg_t cfg;

  assign cfg = '{len: cfg_len_i, par: cfg_par_i, stop: cfg_stop_i, os: cfg_os_i};

  async_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (os_tick_i),
    .cfg_i   (cfg),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .brk_i   (tx_break_i),
    .txd_o   (txd_o)
  );

  async_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .cfg_i     (cfg),
    .rxd_i     (rxd_i),
    .valid_o   (rx_valid_o),
    .data_o    (rx_data_o),
    .par_err_o (rx_par_err_o),
    .frm_err_o (rx_frm_err_o),
    .brk_o     (rx_brk_o)
  );
endmodule

// File: tb/tb_async_xcvr.sv
`timescale 1ns/1ps
module tb_async_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  int   tcount = 0;

  logic [2:0] cfg_len = 3'd7, cfg_par = 3'd0;
  logic [4:0] cfg_stop = 5'd15;
  logic [1:0] cfg_os = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, tx_break = 1'b0;
  logic lb = 1'b1, drv = 1'b1;
  logic tx_ready, txd, rxd, rx_valid, rx_pe, rx_fe, rx_bk;
  logic [7:0] rx_data;

  int ev_cnt = 0;
  logic [7:0] ev_data = '0;
  logic ev_pe = 0, ev_fe = 0, ev_bk = 0;
  int nchk = 0, nfail = 0;
  int t0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  always @(posedge clk) if (tick) tcount <= tcount + 1;

  assign rxd = lb ? txd : drv;

  async_xcvr dut (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick),
    .cfg_len_i(cfg_len), .cfg_par_i(cfg_par), .cfg_stop_i(cfg_stop), .cfg_os_i(cfg_os),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_break_i(tx_break),
    .txd_o(txd), .rxd_i(rxd), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_par_err_o(rx_pe), .rx_frm_err_o(rx_fe), .rx_brk_o(rx_bk)
  );

  always @(posedge clk) if (rx_valid) begin
    ev_cnt  <= ev_cnt + 1;
    ev_data <= rx_data;
    ev_pe   <= rx_pe;
    ev_fe   <= rx_fe;
    ev_bk   <= rx_bk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_tick_to(input int t);
    while (tcount < t) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    wait_tick_to(tcount + n);
  endtask

  task automatic set_cfg(input int l, input int p, input int s, input int o);
    cfg_len = 3'(l); cfg_par = 3'(p); cfg_stop = 5'(s); cfg_os = 2'(o);
  endtask

  function automatic int nt(input int o);
    return (o == 0) ? 16 : (o == 1) ? 32 : 64;
  endfunction

  function automatic logic exp_par(input int pm, input logic [7:0] d, input int nb);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    case (pm)
      1: return (ones % 2) == 0;
      2: return (ones % 2) == 1;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    t0 = tcount;
    tx_valid = 1'b0;
  endtask

  task automatic wait_ev(input int prev, input string tag);
    int lim = tcount + 2000;
    while (ev_cnt == prev && tcount < lim) @(negedge clk);
    chk(tag, ev_cnt, prev + 1);
  endtask

  // sample txd at computed bit centres, then check stop level and ready timing
  task automatic probe_tx(input int n, input int nbits, input int pm, input logic [7:0] d,
                          input int sticks);
    int pe = (pm >= 1 && pm <= 4) ? 1 : 0;
    int nb = 1 + nbits + pe;
    for (int b = 0; b < nb; b++) begin
      wait_tick_to(t0 + b * n + n / 2);
      if (b == 0) chk("R2 start bit", txd, 0);
      else if (b <= nbits) chk("R2 data bit lsb first", txd, d[b-1]);
      else chk("R3 parity bit", txd, exp_par(pm, d, nbits));
    end
    wait_tick_to(t0 + nb * n + sticks - 1);
    chk("R4 stop level", txd, 1);
    chk("R4 ready low before stop end", tx_ready, 0);
    wait_tick_to(t0 + nb * n + sticks);
    chk("R4 ready at stop end", tx_ready, 1);
  endtask

  task automatic drive_frame(input logic [15:0] bits, input int nb, input int n);
    for (int i = 0; i < nb; i++) begin
      drv = bits[i];
      wait_ticks(n);
    end
    drv = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 reset txd", txd, 1);
    chk("R1 reset ready", tx_ready, 1);
    chk("R1 reset rx_valid", rx_valid, 0);
  endtask

  task automatic t_tx_basic;
    int prev = ev_cnt;
    lb = 1; set_cfg(7, 2, 15, 0);
    send(8'hA6);
    probe_tx(16, 8, 2, 8'hA6, 16);
    wait_ev(prev, "R8 event count 8E1");
    chk("R8 rx data 8E1", ev_data, 8'hA6);
    chk("R10 no parity err", ev_pe, 0);
    chk("R11 no framing err", ev_fe, 0);
  endtask

  task automatic t_tx_odd32;
    int prev = ev_cnt;
    set_cfg(4, 1, 23, 1);
    send(8'hF5);
    probe_tx(32, 5, 1, 8'h15, 48);
    wait_ev(prev, "R5 event count 32x");
    chk("R2 rx data masked to length", ev_data, 8'h15);
    chk("R3 odd parity clean", ev_pe, 0);
  endtask

  task automatic t_modes;
    int prev = ev_cnt;
    set_cfg(5, 3, 31, 2);
    send(8'h3C);
    probe_tx(64, 6, 3, 8'h3C, 128);
    wait_ev(prev, "R5 event count 64x");
    chk("R3 mark parity data", ev_data, 8'h3C);
    chk("R3 mark parity clean", ev_pe, 0);

    prev = ev_cnt;
    set_cfg(0, 4, 0, 0);
    send(8'hFF);
    probe_tx(16, 1, 4, 8'h01, 1);
    wait_ev(prev, "R4 event count 1/16 stop");
    chk("R8 one bit char", ev_data, 8'h01);
    chk("R3 space parity clean", ev_pe, 0);

    prev = ev_cnt;
    set_cfg(6, 5, 7, 1);
    send(8'h80);
    probe_tx(32, 7, 5, 8'h00, 16);
    wait_ev(prev, "R3 event count code 5");
    chk("R12 zero data with high stop is not break", ev_bk, 0);
    chk("R8 zero data", ev_data, 8'h00);
    chk("R11 half stop clean", ev_fe, 0);
  endtask

  task automatic t_handshake;
    int prev = ev_cnt;
    set_cfg(7, 0, 15, 0);
    send(8'h3C);
    tx_data = 8'hEE; tx_valid = 1'b1;
    wait_ticks(20);
    chk("R6 ready low while busy", tx_ready, 0);
    tx_valid = 1'b0;
    wait_ev(prev, "R6 event count");
    chk("R6 first byte kept", ev_data, 8'h3C);
    wait_ticks(200);
    chk("R6 busy valid ignored", ev_cnt, prev + 1);
    chk("R1 idle after char", txd, 1);
  endtask

  task automatic t_noise;
    int prev = ev_cnt;
    lb = 0; drv = 1; set_cfg(7, 0, 15, 0);
    wait_ticks(4);
    drv = 0; wait_ticks(4); drv = 1;
    wait_ticks(40);
    chk("R9 glitch dropped", ev_cnt, prev);
    drive_frame({1'b1, 8'h5A, 1'b0}, 10, 16);
    wait_ev(prev, "R9 recovery event");
    chk("R8 driven frame data", ev_data, 8'h5A);
  endtask

  task automatic t_parity;
    int prev = ev_cnt;
    set_cfg(7, 2, 15, 0);
    drive_frame({1'b1, 1'b1, 8'h55, 1'b0}, 11, 16);
    wait_ev(prev, "R10 event even");
    chk("R10 even parity error", ev_pe, 1);
    chk("R10 data kept", ev_data, 8'h55);
    chk("R11 no framing on parity fault", ev_fe, 0);
    prev = ev_cnt;
    set_cfg(7, 3, 15, 0);
    wait_ticks(8);
    drive_frame({1'b1, 1'b0, 8'h0F, 1'b0}, 11, 16);
    wait_ev(prev, "R10 event mark");
    chk("R10 mark parity error", ev_pe, 1);
  endtask

  task automatic t_framing;
    int prev = ev_cnt;
    set_cfg(7, 0, 15, 0);
    wait_ticks(8);
    drive_frame({1'b0, 8'h81, 1'b0}, 10, 16);
    wait_ev(prev, "R11 event");
    chk("R11 framing error", ev_fe, 1);
    chk("R11 data", ev_data, 8'h81);
    chk("R12 not break", ev_bk, 0);
    wait_ticks(40);
    chk("R11 single event", ev_cnt, prev + 1);
  endtask

  task automatic t_break;
    int prev;
    lb = 1; set_cfg(7, 0, 15, 0);
    wait_ticks(8);
    prev = ev_cnt;
    send(8'hFF);
    tx_break = 1'b1;
    wait_tick_to(t0 + 16 + 8);
    chk("R7 char in progress finishes", txd, 1);
    wait_tick_to(t0 + 160 + 2);
    chk("R7 break line low", txd, 0);
    chk("R7 ready low in break", tx_ready, 0);
    chk("R7 char before break", ev_data, 8'hFF);
    wait_ev(prev + 1, "R12 break event");
    chk("R12 break flag", ev_bk, 1);
    chk("R12 break data zero", ev_data, 8'h00);
    chk("R12 break no framing flag", ev_fe, 0);
    wait_ticks(300);
    chk("R12 no start while low", ev_cnt, prev + 2);
    chk("R7 still low", txd, 0);
    tx_break = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 line high after release", txd, 1);
    wait_ticks(4);
    send(8'h42);
    wait_ev(prev + 2, "R12 recovery event");
    chk("R12 recovery data", ev_data, 8'h42);
    chk("R12 recovery not break", ev_bk, 0);
  endtask

  task automatic t_cfg_change;
    int prev = ev_cnt;
    set_cfg(7, 0, 15, 0);
    send(8'hC3);
    wait_ticks(40);
    set_cfg(4, 1, 15, 1);
    wait_ev(prev, "R13 event");
    chk("R13 old config char", ev_data, 8'hC3);
    chk("R13 no parity err", ev_pe, 0);
    chk("R13 no framing err", ev_fe, 0);
    prev = ev_cnt;
    send(8'h0A);
    probe_tx(32, 5, 1, 8'h0A, 32);
    wait_ev(prev, "R13 new config event");
    chk("R13 new config char", ev_data, 8'h0A);
    chk("R13 new config parity", ev_pe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R1: watchdog got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_odd32();
    t_modes();
    t_handshake();
    t_noise();
    t_parity();
    t_framing();
    t_break();
    t_cfg_change();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule